// File: doc/BRIEF.md
# Balanced Partial-Scan Test Sequencer

This controller runs the test procedure for a circuit in which only some registers sit on a scan chain. The unscanned registers form a cycle-free, balanced pipeline between combinational clouds. The scanned registers act as pseudo-primary inputs and outputs.

For each pattern the sequencer does the following, in order:
- It loads the chain.
- It applies the primary-input pattern.
- It clocks the unscanned pipeline exactly `depth` times while the scanned registers and the primary inputs stay frozen.
- It gives the scanned registers one normal-mode clock to capture the results.
- It strobes the primary outputs for observation.

The next load then shifts the captured word out at the same time as it shifts the next pattern in. After the last pattern, one extra shift-only pass empties the chain, and the block signals completion.

Software or a tester sets the chain length, the pipeline depth and the number of patterns, then pulses `start`. Pattern data is not handled here. The surrounding logic drives serial data whenever `scan_en` is high, and it loads the primary inputs on `pi_load`.

Top module: `pscan_test_seq`

## Requirements
- R1: While reset is asserted, and in the idle state after it, every control output (`scan_en`, `pi_load`, `hold`, `capture`, `observe`, `done`) is low.
- R2: A `start` pulse seen in idle is followed, from the next cycle, by exactly `chain_len` consecutive cycles with `scan_en` high (`chain_len` must be at least 1).
- R3: Each load pass that is not the final one is followed by exactly one cycle of `pi_load`.
- R4: After `pi_load`, `hold` is high for exactly `depth` consecutive cycles. When `depth` is 0, `capture` follows `pi_load` directly.
- R5: `capture` lasts exactly one cycle, and the next cycle is a single-cycle `observe`.
- R6: After `observe`, a new pass of exactly `chain_len` shift cycles starts at once, unloading the capture while loading the next pattern. With `pat_count` patterns there are `pat_count`+1 shift passes in total (`pat_count` must be at least 1).
- R7: The final, shift-only pass is followed by exactly one cycle of `done`, and then the block returns to idle.
- R8: A `start` pulse during a run has no effect on the sequence.
- R9: At most one control output is high in any cycle.
- R10: With a depth-2 balanced pipeline as the circuit under test, each unloaded word equals the response to the pattern that preceded it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a run when idle |
| depth | input | DEP_W | Number of pipeline clocks between apply and capture |
| chain_len | input | LEN_W | Scan chain length in bits (at least 1) |
| pat_count | input | PAT_W | Number of patterns in the run (at least 1) |
| scan_en | output | 1 | Shift the scan chain this cycle |
| pi_load | output | 1 | Load the primary-input pattern this cycle |
| hold | output | 1 | Freeze scanned registers and primary inputs; pipeline clocks |
| capture | output | 1 | Scanned registers take their functional input this cycle |
| observe | output | 1 | Primary outputs are valid for comparison this cycle |
| done | output | 1 | One-cycle end-of-run flag |

## Verification
The bench targets the following corner cases:
- Depth 0: a design that entered the pipeline phase anyway would insert a wrong hold cycle.
- Depth 3, and depth 2 with real data: an off-by-one in the depth count would capture the pipeline one stage early or late. The wrong words would then appear on the unload pass.
- One pattern versus several: a design that dropped the final unload pass, or added one, would emit `done` at the wrong time or lose the last response.
- A `start` pulse mid-run: a design that restarted would break the expected sequence.

// File: rtl/pscan_pkg.sv
package pscan_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_SHIFT = 3'd1,
      ST_APPLY = 3'd2,
      ST_PROP  = 3'd3,
      ST_CAPT  = 3'd4,
      ST_OBS   = 3'd5,
      ST_DONE  = 3'd6
   } seq_state_e;

   typedef struct packed {
      logic scan_en;
      logic pi_load;
      logic hold;
      logic capture;
      logic observe;
      logic done;
   } seq_ctl_t;

   function automatic seq_ctl_t decode_ctl(seq_state_e s);
      seq_ctl_t c;
      c = '0;
      case (s)
         ST_SHIFT: c.scan_en = 1'b1;
         ST_APPLY: c.pi_load = 1'b1;
         ST_PROP:  c.hold    = 1'b1;
         ST_CAPT:  c.capture = 1'b1;
         ST_OBS:   c.observe = 1'b1;
         ST_DONE:  c.done    = 1'b1;
         default:  c = '0;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/pscan_downcnt.sv
module pscan_downcnt #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         dec,
   input  logic [W-1:0] init,
   output logic         last
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= init;
      else if (dec && (cnt_q != '0))
         cnt_q <= cnt_q - W'(1);
   end

   assign last = (cnt_q == '0);

endmodule

// File: rtl/pscan_seq_fsm.sv
module pscan_seq_fsm
   import pscan_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       shift_last,
   input  logic       prop_last,
   input  logic       pat_last,
   input  logic       depth_zero,
   output seq_state_e state,
   output logic       ld_shift,
   output logic       dec_shift,
   output logic       ld_prop,
   output logic       dec_prop,
   output logic       ld_pat,
   output logic       dec_pat
);

   seq_state_e state_q, state_d;
   logic       unload_q;

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE:  if (start) state_d = ST_SHIFT;
         ST_SHIFT: if (shift_last) state_d = unload_q ? ST_DONE : ST_APPLY;
         ST_APPLY: state_d = depth_zero ? ST_CAPT : ST_PROP;
         ST_PROP:  if (prop_last) state_d = ST_CAPT;
         ST_CAPT:  state_d = ST_OBS;
         ST_OBS:   state_d = ST_SHIFT;
         ST_DONE:  state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         unload_q <= 1'b0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_IDLE && start)
            unload_q <= 1'b0;
         else if (state_q == ST_OBS && pat_last)
            unload_q <= 1'b1;
      end
   end

   assign state     = state_q;
   assign ld_shift  = (state_q == ST_IDLE && start) || (state_q == ST_OBS);
   assign dec_shift = (state_q == ST_SHIFT);
   assign ld_prop   = (state_q == ST_APPLY) && !depth_zero;
   assign dec_prop  = (state_q == ST_PROP);
   assign ld_pat    = (state_q == ST_IDLE) && start;
   assign dec_pat   = (state_q == ST_OBS) && !pat_last;

endmodule

// File: rtl/pscan_test_seq.sv
module pscan_test_seq
   import pscan_pkg::*;
#(
   parameter int LEN_W = 8,
   parameter int DEP_W = 4,
   parameter int PAT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [DEP_W-1:0] depth,
   input  logic [LEN_W-1:0] chain_len,
   input  logic [PAT_W-1:0] pat_count,
   output logic             scan_en,
   output logic             pi_load,
   output logic             hold,
   output logic             capture,
   output logic             observe,
   output logic             done
);

   localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);
   localparam logic [DEP_W-1:0] DEP_ONE = DEP_W'(1);
   localparam logic [PAT_W-1:0] PAT_ONE = PAT_W'(1);

   generate
      if (LEN_W < 1 || LEN_W > 24) begin : g_bad_len
         $error("pscan_test_seq: LEN_W out of range");
      end
      if (DEP_W < 1 || DEP_W > 16) begin : g_bad_dep
         $error("pscan_test_seq: DEP_W out of range");
      end
      if (PAT_W < 1 || PAT_W > 24) begin : g_bad_pat
         $error("pscan_test_seq: PAT_W out of range");
      end
   endgenerate

   seq_state_e state;
   seq_ctl_t   ctl;
   logic shift_last, prop_last, pat_last;
   logic ld_shift, dec_shift, ld_prop, dec_prop, ld_pat, dec_pat;

   pscan_downcnt #(.W(LEN_W)) u_shift_cnt (
      .clk(clk), .rst_n(rst_n), .load(ld_shift), .dec(dec_shift),
      .init(chain_len - LEN_ONE), .last(shift_last)
   );

   pscan_downcnt #(.W(DEP_W)) u_prop_cnt (
      .clk(clk), .rst_n(rst_n), .load(ld_prop), .dec(dec_prop),
      .init(depth - DEP_ONE), .last(prop_last)
   );

   pscan_downcnt #(.W(PAT_W)) u_pat_cnt (
      .clk(clk), .rst_n(rst_n), .load(ld_pat), .dec(dec_pat),
      .init(pat_count - PAT_ONE), .last(pat_last)
   );

   pscan_seq_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .start(start),
      .shift_last(shift_last), .prop_last(prop_last), .pat_last(pat_last),
      .depth_zero(depth == '0), .state(state),
      .ld_shift(ld_shift), .dec_shift(dec_shift),
      .ld_prop(ld_prop), .dec_prop(dec_prop),
      .ld_pat(ld_pat), .dec_pat(dec_pat)
   );

   always_comb ctl = decode_ctl(state);

   assign scan_en = ctl.scan_en;
   assign pi_load = ctl.pi_load;
   assign hold    = ctl.hold;
   assign capture = ctl.capture;
   assign observe = ctl.observe;
   assign done    = ctl.done;

endmodule

// File: rtl/pscan_test_seq_chk.sv
module pscan_test_seq_chk #(
   parameter int LEN_W = 8,
   parameter int DEP_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic [DEP_W-1:0] depth,
   input logic [LEN_W-1:0] chain_len,
   input logic             scan_en,
   input logic             pi_load,
   input logic             hold,
   input logic             capture,
   input logic             observe,
   input logic             done
);

   logic [LEN_W:0] sh_run;
   logic [DEP_W:0] hd_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_run <= '0;
         hd_run <= '0;
      end else begin
         sh_run <= scan_en ? sh_run + 1'b1 : '0;
         hd_run <= hold ? hd_run + 1'b1 : '0;
      end
   end

   assert_shift_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!scan_en && sh_run != '0) |-> (sh_run == {1'b0, chain_len}));

   assert_shift_to_apply_R3: assert property (@(posedge clk) disable iff (!rst_n)
      pi_load |-> $past(scan_en));

   assert_hold_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold && hd_run != '0) |-> (hd_run == {1'b0, depth}));

   assert_zero_depth_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (pi_load && depth == '0) |=> capture);

   assert_capt_obs_R5: assert property (@(posedge clk) disable iff (!rst_n)
      capture |=> (observe && !capture));

   assert_obs_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
      observe |=> scan_en);

   assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !scan_en));

   assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({scan_en, pi_load, hold, capture, observe, done}));

endmodule

bind pscan_test_seq pscan_test_seq_chk #(.LEN_W(LEN_W), .DEP_W(DEP_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .depth(depth), .chain_len(chain_len),
   .scan_en(scan_en), .pi_load(pi_load), .hold(hold), .capture(capture),
   .observe(observe), .done(done)
);

// File: tb/sim_pscan_test_seq.sv
module sim_pscan_test_seq;
   localparam int LW = 8, DW = 4, PW = 8, W = 8;

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
   logic [DW-1:0] dep = '0;
   logic [LW-1:0] len = LW'(W);
   logic [PW-1:0] npat = PW'(1);
   logic scan_en, pi_load, hold, capture, observe, done;

   int checks = 0, errors = 0;
   bit finished = 0, cmp_on = 0;

   pscan_test_seq #(.LEN_W(LW), .DEP_W(DW), .PAT_W(PW)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .depth(dep), .chain_len(len),
      .pat_count(npat), .scan_en(scan_en), .pi_load(pi_load), .hold(hold),
      .capture(capture), .observe(observe), .done(done)
   );

   always #2.5 clk = ~clk;

   // behavioural circuit under test: chain, PI register, two pipeline stages
   logic [W-1:0] pats [4] = '{8'hA5, 8'h3C, 8'hF0, 8'h01};
   logic [W-1:0] pis  [4] = '{8'h0F, 8'h99, 8'h12, 8'hFE};
   logic [W-1:0] s_reg = '0, pi_q = '0, r1 = '0, r2 = '0;
   int pass = 0, sh_idx = 0, n_cur = 0;
   logic si;
   logic [W-1:0] pi_bus;
   bit unl_q[$];

   function automatic logic [W-1:0] cut_g(logic [W-1:0] x);
      return {x[W-2:0], x[W-1]} ^ 8'h5A;
   endfunction

   assign si     = (pass < n_cur) ? pats[pass][W-1-sh_idx] : 1'b0;
   assign pi_bus = (pass > 0 && pass <= n_cur) ? pis[pass-1] : '0;

   always @(posedge clk) begin
      if (pi_load) pi_q <= pi_bus;
      r1 <= s_reg ^ pi_q;
      r2 <= r1;
      if (scan_en) begin
         s_reg <= {s_reg[W-2:0], si};
         unl_q.push_back(s_reg[W-1]);
         if (sh_idx == W-1) begin
            sh_idx <= 0;
            pass   <= pass + 1;
         end else sh_idx <= sh_idx + 1;
      end else if (capture) s_reg <= cut_g(r2);
   end

   // cycle-by-cycle expected control vector {scan_en,pi_load,hold,capture,observe,done}
   logic [5:0] exp_q[$];
   string      req_q[$];

   task automatic push(logic [5:0] v, string r, int n);
      for (int i = 0; i < n; i++) begin exp_q.push_back(v); req_q.push_back(r); end
   endtask

   task automatic check(bit ok, string r, string what, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (cmp_on) begin
         logic [5:0] act, e;
         string r;
         act = {scan_en, pi_load, hold, capture, observe, done};
         if (exp_q.size() > 0) begin e = exp_q.pop_front(); r = req_q.pop_front(); end
         else begin e = '0; r = "R7"; end
         check(act == e, r, "control vector", act, e);
         check($countones(act) <= 1, "R9", "exclusive outputs", act, 0);
      end
   end

   task automatic run(int n, int d, bit poke);
      @(posedge clk); #1;
      n_cur = n; pass <= 0; sh_idx <= 0; unl_q.delete();
      npat = PW'(n); dep = DW'(d);
      push(6'b000000, "R1", 1);
      for (int p = 0; p < n; p++) begin
         push(6'b100000, (p == 0) ? "R2" : "R6", W);
         push(6'b010000, "R3", 1);
         push(6'b001000, "R4", d);
         push(6'b000100, (d == 0) ? "R4" : "R5", 1);
         push(6'b000010, "R5", 1);
      end
      push(6'b100000, "R6", W);
      push(6'b000001, "R7", 1);
      push(6'b000000, "R7", 3);
      start = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
      if (poke) begin
         repeat (5) @(posedge clk);
         #1 start = 1'b1;   // R8: pulse while busy, sequence must not change
         @(posedge clk); #1 start = 1'b0;
      end
      wait (exp_q.size() == 0);
      @(posedge clk); #1;
   endtask

   task automatic check_data(int n);
      checks++;
      if (unl_q.size() != W * (n + 1)) begin
         errors++;
         $display("FAIL R6 unloaded bit count: actual %0d expected %0d", unl_q.size(), W * (n + 1));
      end else
         for (int p = 0; p < n; p++) begin
            logic [W-1:0] word, e;
            word = '0;
            for (int i = 0; i < W; i++) word = {word[W-2:0], unl_q[(p + 1) * W + i]};
            e = cut_g(pats[p] ^ pis[p]);
            check(word == e, "R10", "captured response", word, e);
         end
   endtask

   initial begin
      repeat (3) begin
         @(negedge clk);
         check({scan_en, pi_load, hold, capture, observe, done} == 6'b0, "R1", "reset outputs",
               {scan_en, pi_load, hold, capture, observe, done}, 0);
      end
      @(posedge clk); #1 rst_n = 1'b1;
      cmp_on = 1;
      repeat (3) @(posedge clk);
      run(3, 2, 1'b1);
      check_data(3);
      run(1, 0, 1'b0);
      run(2, 3, 1'b0);
      run(1, 2, 1'b0);
      check_data(1);
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL R7 watchdog: actual running expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule